// File: doc/BRIEF.md
# Character Cell Attribute Pipeline

This block shapes the per-character display attributes of a text-mode video path. Each character cell carries four flags: blink, bold, reverse and underline. The flags enter a first register on a load strobe. On a separate character-phase strobe they move into an output register, which drives the video converter that modulates the pixel stream.

Two signals outside the cell act on the flags as they pass through.

- **Scan-line address.** The underline flag only produces an output on a fixed window of scan lines inside the cell.
- **Screen-wide inversion control.** This signal is XORed with the per-cell reverse flag at the output stage, so one bit can invert the whole screen.

The first register is forced to zero while the screen is blanked outside active line time. As a result, retrace intervals never carry stale attributes. All storage runs on one system clock, with single-cycle enable strobes.

Top module: `vid_attr_pipe`

## Requirements
- R1: While reset is asserted, and after reset is released, every attribute output is 0.
- R2: When `cell_load` is high and the clear condition is absent, the first register takes `cell_attr` on that clock edge. Bit 0 is blink, bit 1 is bold, bit 2 is reverse and bit 3 is underline. With neither load nor clear, the first register holds its value.
- R3: When `blank` is 1 and `line_active` is 0, the first register is cleared to 0 on that edge. The clear wins over a simultaneous `cell_load`.
- R4: When `blank` is 1 and `line_active` is 1, the first register is not cleared.
- R5: `ul_out` is 1 after a `phase_stb` edge only if two things held at that strobe: the stored underline flag was 1, and `scan_line` was 8 or 9. For any other scan-line value, `ul_out` is 0.
- R6: The output register changes only on a clock edge where `phase_stb` is 1. Otherwise it holds its value, whatever the other inputs do.
- R7: On a strobe, `rev_out` becomes the stored reverse flag XOR `field_inv`.
- R8: On a strobe, `blink_out` and `bold_out` take the stored blink and bold flags unchanged.
- R9: With `field_inv` = 1 and a stored reverse flag of 0, `rev_out` is 1 after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cell_load | input | 1 | Load strobe for the first attribute register |
| cell_attr | input | 4 | Cell flags: bit 0 blink, bit 1 bold, bit 2 reverse, bit 3 underline |
| blank | input | 1 | Composite blank, active high |
| line_active | input | 1 | Active line time, active high |
| scan_line | input | 4 | Scan-line address within the character cell, counted from 0 |
| field_inv | input | 1 | Screen-wide inversion control |
| phase_stb | input | 1 | Character-phase strobe that loads the output register |
| blink_out | output | 1 | Registered blink attribute |
| bold_out | output | 1 | Registered bold attribute |
| rev_out | output | 1 | Registered reverse attribute after inversion |
| ul_out | output | 1 | Registered, scan-line gated underline |

## Verification
Loads and clears of the first register take effect on the edge where they are sampled. They reach the outputs only through a later strobe, so a new attribute appears one edge after the first `phase_stb` that follows its load. Each strobe result is due on the edge where `phase_stb` is sampled, and is visible from the next falling edge.

For every driven cycle, the driver pushes the expected output word and a requirement tag into a queue. The monitor pops that entry at the following falling edge, so each comparison falls exactly one registered stage after its stimulus. Cycles without a strobe also push an entry, which carries the hold expectation.

// File: rtl/vattr_pkg.sv
package vattr_pkg;

  typedef struct packed {
    logic ul;
    logic rev;
    logic bold;
    logic blink;
  } attr_t;

  localparam int ATTR_W = $bits(attr_t);

endpackage

// File: rtl/vattr_rst_sync.sv
module vattr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_r <= '0;
    else        sync_r <= {sync_r[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_r[STAGES-1];

endmodule

// File: rtl/vattr_capture.sv
module vattr_capture
  import vattr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  attr_t attr_i,
  input  logic  blank_i,
  input  logic  line_act_i,
  output attr_t attr_o
);

  logic  clr;
  logic  en;
  attr_t q_d;
  attr_t q_r;

  // Clearing takes priority over loading.
  always_comb begin
    clr = blank_i & ~line_act_i;
    en  = clr | load_i;
    q_d = q_r;
    if (clr)         q_d = '0;
    else if (load_i) q_d = attr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (en) q_r <= q_d;
  end

  assign attr_o = q_r;

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_i && !line_act_i) |=> (attr_o == '0));

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !(blank_i && !line_act_i)) |=> (attr_o == $past(attr_i)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !(blank_i && !line_act_i)) |=> $stable(attr_o));

  assert_no_clear_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_i && line_act_i && !load_i) |=> $stable(attr_o));

endmodule

// File: rtl/vattr_ul_gate.sv
module vattr_ul_gate #(
  parameter int SCAN_W   = 4,
  parameter int UL_FIRST = 8,
  parameter int UL_LAST  = 9
) (
  input  logic              ul_flag_i,
  input  logic [SCAN_W-1:0] scan_i,
  output logic              ul_o
);

  localparam logic [SCAN_W-1:0] FIRST_L = SCAN_W'(UL_FIRST);
  localparam logic [SCAN_W-1:0] LAST_L  = SCAN_W'(UL_LAST);

  logic in_win;

  generate
    if (UL_FIRST == UL_LAST) begin : g_single
      assign in_win = (scan_i == FIRST_L);
    end else begin : g_range
      assign in_win = (scan_i >= FIRST_L) && (scan_i <= LAST_L);
    end
  endgenerate

  assign ul_o = ul_flag_i & in_win;

endmodule

// File: rtl/vattr_out_reg.sv
module vattr_out_reg
  import vattr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  stb_i,
  input  attr_t attr_i,
  input  logic  ul_gated_i,
  input  logic  field_inv_i,
  output attr_t out_o
);

  attr_t d;
  attr_t q_r;

  always_comb begin
    d       = q_r;
    if (stb_i) begin
      d.blink = attr_i.blink;
      d.bold  = attr_i.bold;
      d.rev   = attr_i.rev ^ field_inv_i;
      d.ul    = ul_gated_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_r <= '0;
    else if (stb_i) q_r <= d;
  end

  assign out_o = q_r;

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> $stable(out_o));

  assert_rev_xor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i |=> (out_o.rev == ($past(attr_i.rev) ^ $past(field_inv_i))));

  assert_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i |=> (out_o.blink == $past(attr_i.blink)) && (out_o.bold == $past(attr_i.bold)));

  assert_invert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && field_inv_i && !attr_i.rev) |=> out_o.rev);

endmodule

// File: rtl/vid_attr_pipe.sv
module vid_attr_pipe
  import vattr_pkg::*;
#(
  parameter int SCAN_W   = 4,
  parameter int UL_FIRST = 8,
  parameter int UL_LAST  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_load,
  input  logic [3:0]        cell_attr,
  input  logic              blank,
  input  logic              line_active,
  input  logic [SCAN_W-1:0] scan_line,
  input  logic              field_inv,
  input  logic              phase_stb,
  output logic              blink_out,
  output logic              bold_out,
  output logic              rev_out,
  output logic              ul_out
);

  logic  rst_int_n;
  attr_t stage1;
  attr_t stage2;
  logic  ul_gated;

  vattr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  vattr_capture u_cap (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (cell_load),
    .attr_i     (attr_t'(cell_attr)),
    .blank_i    (blank),
    .line_act_i (line_active),
    .attr_o     (stage1)
  );

  vattr_ul_gate #(
    .SCAN_W   (SCAN_W),
    .UL_FIRST (UL_FIRST),
    .UL_LAST  (UL_LAST)
  ) u_ul (
    .ul_flag_i (stage1.ul),
    .scan_i    (scan_line),
    .ul_o      (ul_gated)
  );

  vattr_out_reg u_out (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .stb_i       (phase_stb),
    .attr_i      (stage1),
    .ul_gated_i  (ul_gated),
    .field_inv_i (field_inv),
    .out_o       (stage2)
  );

  assign blink_out = stage2.blink;
  assign bold_out  = stage2.bold;
  assign rev_out   = stage2.rev;
  assign ul_out    = stage2.ul;

  assert_ul_window_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    phase_stb |=> (ul_out == ($past(stage1.ul) &&
                              ($past(scan_line) >= SCAN_W'(UL_FIRST)) &&
                              ($past(scan_line) <= SCAN_W'(UL_LAST)))));

  assert_reset_R1: assert property (@(posedge clk)
    !rst_int_n |-> !(blink_out || bold_out || rev_out || ul_out));

endmodule

// File: tb/test_vid_attr_pipe.sv
module test_vid_attr_pipe;

  logic       clk;
  logic       rst_n;
  logic       cell_load;
  logic [3:0] cell_attr;
  logic       blank;
  logic       line_active;
  logic [3:0] scan_line;
  logic       field_inv;
  logic       phase_stb;
  logic       blink_out, bold_out, rev_out, ul_out;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  // Reference model state; bit order {ul, rev, bold, blink}.
  logic [3:0] m_s1;
  logic [3:0] m_out;

  vid_attr_pipe i_vid_attr_pipe (
    .clk(clk), .rst_n(rst_n), .cell_load(cell_load), .cell_attr(cell_attr),
    .blank(blank), .line_active(line_active), .scan_line(scan_line),
    .field_inv(field_inv), .phase_stb(phase_stb),
    .blink_out(blink_out), .bold_out(bold_out), .rev_out(rev_out), .ul_out(ul_out)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic ld, input logic [3:0] a, input logic blk,
                      input logic lact, input logic stb, input logic [3:0] sc,
                      input logic fld, input string tag);
    logic [3:0] nxt;
    @(negedge clk);
    cell_load = ld; cell_attr = a; blank = blk; line_active = lact;
    phase_stb = stb; scan_line = sc; field_inv = fld;
    @(posedge clk);
    if (stb) begin
      nxt[0] = m_s1[0];
      nxt[1] = m_s1[1];
      nxt[2] = m_s1[2] ^ fld;
      nxt[3] = m_s1[3] && (sc == 4'd8 || sc == 4'd9);
      m_out  = nxt;
    end
    if (blk && !lact)  m_s1 = 4'b0;
    else if (ld)       m_s1 = a;
    exp_q.push_back(m_out);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {ul_out, rev_out, bold_out, blink_out}, e);
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cell_load = 0; cell_attr = 0; blank = 0; line_active = 1;
    scan_line = 0; field_inv = 0; phase_stb = 0;
    m_s1 = 0; m_out = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset", {ul_out, rev_out, bold_out, blink_out}, 4'b0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 after release", {ul_out, rev_out, bold_out, blink_out}, 4'b0);

    // R2 load, R6 no strobe keeps outputs
    step(1, 4'b0011, 0, 1, 0, 0, 0, "R2_R6 load no strobe");
    step(0, 4'b1111, 0, 1, 1, 0, 0, "R8 blink bold pass");
    // R7 reverse xor
    step(1, 4'b0100, 0, 1, 0, 0, 0, "R6 hold");
    step(0, 4'b0000, 0, 1, 1, 0, 0, "R7 rev field0");
    step(0, 4'b0000, 0, 1, 1, 0, 1, "R7 rev field1");
    step(1, 4'b0000, 0, 1, 0, 0, 1, "R6 hold field");
    step(0, 4'b0000, 0, 1, 1, 0, 1, "R9 screen invert");
    // R5 underline window
    step(1, 4'b1000, 0, 1, 0, 0, 0, "R6 hold ul load");
    step(0, 4'b0000, 0, 1, 1, 7, 0, "R5 line 7");
    step(0, 4'b0000, 0, 1, 1, 8, 0, "R5 line 8");
    step(0, 4'b0000, 0, 1, 1, 9, 0, "R5 line 9");
    step(0, 4'b0000, 0, 1, 1, 10, 0, "R5 line 10");
    step(0, 4'b0000, 0, 1, 1, 15, 0, "R5 line 15");
    step(0, 4'b0000, 0, 1, 0, 3, 1, "R6 no strobe field change");
    // R3 clear beats load
    step(1, 4'b1111, 1, 0, 0, 8, 0, "R3 clear over load");
    step(0, 4'b0000, 0, 1, 1, 8, 0, "R3 cleared output");
    // R4 blank in active line keeps value
    step(1, 4'b1111, 0, 1, 0, 0, 0, "R2 load all");
    step(0, 4'b0000, 1, 1, 0, 0, 0, "R4 blank active");
    step(0, 4'b0000, 0, 1, 1, 9, 0, "R4 kept all flags");
    step(0, 4'b0000, 0, 1, 1, 9, 1, "R7 rev cancelled");
    step(0, 4'b0000, 0, 1, 0, 0, 0, "idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule